// File: doc/BRIEF.md
# Divider-Tuning Ratio Search Loop

The block finds the integer ratio between a fast input pulse stream and a slower reference pulse stream with a closed feedback loop. It does not count directly. Both streams first pass through the same fixed prescaler. The input stream then also passes through a programmable divider D. The two results drive one saturating up/down accumulator: a divided-input pulse counts up and a divided-reference pulse counts down. A window covers a fixed number of divided-reference pulses. At the end of each window a controller reads the net drift. It raises D if the input side ran ahead, lowers D if the input side fell behind, and otherwise counts the window as balanced.

A pulse on the start input loads D with its midpoint and begins the search. The loop keeps running after it finds the ratio. It reports lock after two balanced windows in a row, and it drops lock as soon as a window drifts. D is clamped to a legal range, and a status flag shows a step request past either limit. Edge inputs are single-cycle pulses already synchronous to the clock; the analog conditioning that produces them lies outside the block.

Top module: `ratio_search`

## Requirements
- R1: After reset, `div_o` equals DMID (15), `locked_o`, `too_high_o` and `too_low_o` are 0. Until the first `start_i` pulse, edge pulses change none of these outputs.
- R2: A `start_i` pulse sets `div_o` to DMID on the next cycle and clears `locked_o`, `too_high_o` and `too_low_o`.
- R3: At each window end, D rises by one when net drift (input pulses minus reference pulses) exceeds +TH (2), falls by one when it is below −TH, and is otherwise held. D never changes by more than one per window.
- R4: `div_o` always stays within DMIN (10) to DMAX (20).
- R5: `too_high_o` is set when a window asks for a step above DMAX, and `too_low_o` when one asks for a step below DMIN. D then holds. A window that asks for no such step, or a start, clears the flag, and the two flags are never set together.
- R6: `locked_o` rises only at the end of the second balanced window in a row, never after a single one.
- R7: `locked_o` falls at the end of any window whose drift exceeds the threshold.
- R8: With an integer ratio N between DMIN and DMAX, D settles at N, `locked_o` asserts, and both stay put while the ratio is unchanged. A window spans WIN divided-reference pulses, and PRE divides both paths while D divides only the input path.
- R9: The accumulator reloads its midpoint at each window start and saturates at its rails instead of wrapping. An extreme drift therefore still gives exactly one step, in the correct direction, per window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse: load DMID and begin the search |
| in_edge_i | input | 1 | Single-cycle pulse per input-signal edge |
| ref_edge_i | input | 1 | Single-cycle pulse per reference edge |
| div_o | output | DIV_W | Current divider value D |
| locked_o | output | 1 | Ratio found and stable |
| too_high_o | output | 1 | A step above DMAX was requested |
| too_low_o | output | 1 | A step below DMIN was requested |

## Verification
The bench builds the block with PRE=2, WIN=64 and a narrow 6-bit accumulator. The small prescaler keeps a window near 128·N clocks, so full searches from 15 up to 20 and down to 10 fit in the run. A 64-pulse window separates adjacent D values by more than the threshold even at N=20. The narrow accumulator lets a ratio of 40 push the drift onto its rail, so saturation, rather than wrapping, shows up at the ports as a correct upward step.

// File: rtl/ratio_search_pkg.sv
package ratio_search_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/pulse_divider.sv
module pulse_divider #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         pulse_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= 1'b0;
      if (pulse_i) begin
        // >= so a shrinking ratio never strands the count
        if (cnt_q >= ratio_i - W'(1)) begin
          cnt_q <= '0;
          out_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + W'(1);
        end
      end
    end
  end

  assign pulse_o = out_q;

  AST_OUT_NEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(pulse_i)); // R8
endmodule

// File: rtl/updown_acc.sv
module updown_acc #(
  parameter int ACC_W = 10,
  localparam int NET_W = ACC_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  output logic signed [NET_W-1:0] net_o
);
  localparam logic [ACC_W-1:0] MAXV = '1;
  localparam logic [ACC_W-1:0] MIDV = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc_q, base, acc_d;

  always_comb begin
    base  = clr_i ? MIDV : acc_q;
    acc_d = base;
    if (up_i && !dn_i && base != MAXV) acc_d = base + ACC_W'(1);
    if (dn_i && !up_i && base != '0)   acc_d = base - ACC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= MIDV;
    else         acc_q <= acc_d;
  end

  assign net_o = $signed({1'b0, acc_q}) - $signed({1'b0, MIDV});

  AST_ACC_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == MAXV && up_i && !dn_i && !clr_i) |=> acc_q == MAXV); // R9
  AST_ACC_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == '0 && dn_i && !up_i && !clr_i) |=> acc_q == '0); // R9
  AST_ACC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !up_i && !dn_i) |=> acc_q == MIDV); // R9
endmodule

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import ratio_search_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int DMIN  = 10,
  parameter int DMAX  = 20,
  parameter int DMID  = 15,
  parameter int WIN   = 64,
  parameter int TH    = 2,
  parameter int NET_W = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    ref_div_i,
  input  logic signed [NET_W-1:0] net_i,
  output logic                    run_o,
  output logic                    acc_clr_o,
  output logic [DIV_W-1:0]        div_o,
  output logic                    locked_o,
  output logic                    too_high_o,
  output logic                    too_low_o
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WIN_W-1:0]        WIN_LAST = WIN_W'(WIN - 1);
  localparam logic [DIV_W-1:0]        D_MIN = DIV_W'(DMIN);
  localparam logic [DIV_W-1:0]        D_MAX = DIV_W'(DMAX);
  localparam logic [DIV_W-1:0]        D_MID = DIV_W'(DMID);
  localparam logic signed [NET_W-1:0] TH_P  = NET_W'(TH);
  localparam logic signed [NET_W-1:0] TH_N  = -TH_P;

  logic             run_q, eval_q, bal_q, locked_q, hi_q, lo_q;
  logic [WIN_W-1:0] win_q;
  logic [DIV_W-1:0] div_q;
  step_e            step;

  always_comb begin
    if (net_i > TH_P)      step = STEP_UP;
    else if (net_i < TH_N) step = STEP_DOWN;
    else                   step = STEP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      eval_q   <= 1'b0;
      win_q    <= '0;
      div_q    <= D_MID;
      bal_q    <= 1'b0;
      locked_q <= 1'b0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else if (start_i) begin
      run_q    <= 1'b1;
      eval_q   <= 1'b0;
      win_q    <= '0;
      div_q    <= D_MID;
      bal_q    <= 1'b0;
      locked_q <= 1'b0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else if (run_q) begin
      eval_q <= ref_div_i && (win_q == WIN_LAST);
      if (ref_div_i) win_q <= (win_q == WIN_LAST) ? '0 : win_q + WIN_W'(1);
      if (eval_q) begin
        unique case (step)
          STEP_UP: begin
            bal_q    <= 1'b0;
            locked_q <= 1'b0;
            lo_q     <= 1'b0;
            if (div_q >= D_MAX) hi_q <= 1'b1;
            else begin
              hi_q  <= 1'b0;
              div_q <= div_q + DIV_W'(1);
            end
          end
          STEP_DOWN: begin
            bal_q    <= 1'b0;
            locked_q <= 1'b0;
            hi_q     <= 1'b0;
            if (div_q <= D_MIN) lo_q <= 1'b1;
            else begin
              lo_q  <= 1'b0;
              div_q <= div_q - DIV_W'(1);
            end
          end
          default: begin
            hi_q     <= 1'b0;
            lo_q     <= 1'b0;
            bal_q    <= 1'b1;
            locked_q <= bal_q; // second balanced window in a row
          end
        endcase
      end
    end
  end

  assign run_o      = run_q;
  assign acc_clr_o  = start_i || eval_q;
  assign div_o      = div_q;
  assign locked_o   = locked_q;
  assign too_high_o = hi_q;
  assign too_low_o  = lo_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> ($stable(div_q) && !locked_q && !hi_q && !lo_q)); // R1
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (div_q == D_MID && !locked_q)); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(div_q) && !$past(start_i)) |->
      (div_q == $past(div_q) + DIV_W'(1) || div_q == $past(div_q) - DIV_W'(1))); // R3
  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q >= D_MIN && div_q <= D_MAX)); // R4
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q)); // R5
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(eval_q) && $past(bal_q))); // R6
  AST_DRIFT_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && eval_q && step != STEP_HOLD) |=> !locked_q); // R7
endmodule

// File: rtl/ratio_search.sv
module ratio_search #(
  parameter int PRE   = 8,
  parameter int DIV_W = 5,
  parameter int DMIN  = 10,
  parameter int DMAX  = 20,
  parameter int DMID  = 15,
  parameter int WIN   = 64,
  parameter int TH    = 2,
  parameter int ACC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_edge_i,
  input  logic             ref_edge_i,
  output logic [DIV_W-1:0] div_o,
  output logic             locked_o,
  output logic             too_high_o,
  output logic             too_low_o
);
  localparam int PRE_W = $clog2(PRE + 1);
  localparam int NET_W = ACC_W + 1;

  logic [1:0]              raw_edge, pre_edge;
  logic                    in_div, run, acc_clr;
  logic signed [NET_W-1:0] net;

  assign raw_edge = {ref_edge_i, in_edge_i};

  // identical fixed prescale on both paths
  for (genvar g = 0; g < 2; g++) begin : g_pre
    pulse_divider #(.W(PRE_W)) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start_i),
      .pulse_i (raw_edge[g]),
      .ratio_i (PRE_W'(PRE)),
      .pulse_o (pre_edge[g])
    );
  end

  pulse_divider #(.W(DIV_W)) u_pdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .pulse_i (pre_edge[0]),
    .ratio_i (div_o),
    .pulse_o (in_div)
  );

  updown_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc_clr),
    .up_i   (run && in_div),
    .dn_i   (run && pre_edge[1]),
    .net_o  (net)
  );

  ratio_ctrl #(
    .DIV_W (DIV_W),
    .DMIN  (DMIN),
    .DMAX  (DMAX),
    .DMID  (DMID),
    .WIN   (WIN),
    .TH    (TH),
    .NET_W (NET_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ref_div_i  (pre_edge[1]),
    .net_i      (net),
    .run_o      (run),
    .acc_clr_o  (acc_clr),
    .div_o      (div_o),
    .locked_o   (locked_o),
    .too_high_o (too_high_o),
    .too_low_o  (too_low_o)
  );
endmodule

// File: tb/ratio_search_test.sv
module ratio_search_test;
  localparam int PRE = 2;
  localparam int WIN = 64;
  localparam int DIV_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_edge = 1'b0;
  logic ref_edge = 1'b0;
  logic gen_on = 1'b0;
  int   ref_per = 15;
  logic [DIV_W-1:0] div;
  logic locked, too_high, too_low;
  int   errors = 0;
  int   checks = 0;

  always #2 clk = ~clk; // 250 MHz

  ratio_search #(
    .PRE(PRE), .DIV_W(DIV_W), .DMIN(10), .DMAX(20), .DMID(15),
    .WIN(WIN), .TH(2), .ACC_W(6)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .in_edge_i(in_edge), .ref_edge_i(ref_edge),
    .div_o(div), .locked_o(locked), .too_high_o(too_high), .too_low_o(too_low)
  );

  // input edge every clock, reference edge every ref_per clocks: ratio = ref_per
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      in_edge  = gen_on;
      ref_edge = gen_on && (c == 0);
      c = (c + 1 >= ref_per) ? 0 : c + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int win_cycles(input int n);
    return WIN * PRE * n;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_lock(input int max_cycles);
    for (int i = 0; i < max_cycles; i++) begin
      @(negedge clk);
      if (locked) break;
    end
  endtask

  task automatic t_reset_idle();
    @(negedge clk);
    chk("R1 div after reset", int'(div), 15);
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 flags after reset", int'({too_high, too_low}), 0);
    ref_per = 30;
    gen_on  = 1'b1;
    repeat (3000) @(negedge clk);
    chk("R1 div idle", int'(div), 15);
    chk("R1 too_high idle", int'(too_high), 0);
  endtask

  task automatic t_lock_two();
    ref_per = 15;
    pulse_start();
    chk("R2 div on start", int'(div), 15);
    repeat (win_cycles(15) * 3 / 2) @(negedge clk);
    chk("R6 no lock after one window", int'(locked), 0);
    repeat (win_cycles(15)) @(negedge clk);
    chk("R6 lock after two windows", int'(locked), 1);
    chk("R8 div at ratio 15", int'(div), 15);
  endtask

  task automatic t_drift_up();
    ref_per = 18;
    for (int i = 0; i < 2 * win_cycles(18) + 100; i++) begin
      @(negedge clk);
      if (!locked) break;
    end
    chk("R7 lock drops on drift", int'(locked), 0);
    wait_lock(10 * win_cycles(18));
    chk("R8 relock at 18", int'(locked), 1);
    chk("R3 div stepped up to 18", int'(div), 18);
    repeat (3 * win_cycles(18)) @(negedge clk);
    chk("R8 div holds", int'(div), 18);
    chk("R8 lock holds", int'(locked), 1);
  endtask

  task automatic t_drift_down();
    ref_per = 12;
    repeat (win_cycles(12)) @(negedge clk);
    wait_lock(10 * win_cycles(12));
    chk("R3 lock at 12", int'(locked), 1);
    chk("R3 div stepped down to 12", int'(div), 12);
  endtask

  task automatic t_high();
    ref_per = 22;
    for (int i = 0; i < 12 * win_cycles(22); i++) begin
      @(negedge clk);
      if (too_high) break;
    end
    chk("R5 too_high set", int'(too_high), 1);
    chk("R4 div clamped at max", int'(div), 20);
    chk("R6 no lock out of range", int'(locked), 0);
  endtask

  task automatic t_low();
    ref_per = 8;
    for (int i = 0; i < 15 * win_cycles(8); i++) begin
      @(negedge clk);
      if (too_low) break;
    end
    chk("R5 too_low set", int'(too_low), 1);
    chk("R5 too_high cleared", int'(too_high), 0);
    chk("R4 div clamped at min", int'(div), 10);
  endtask

  task automatic t_saturate();
    ref_per = 40;
    pulse_start();
    chk("R2 div reload", int'(div), 15);
    chk("R2 flags cleared", int'({too_high, too_low}), 0);
    chk("R2 lock cleared", int'(locked), 0);
    repeat (win_cycles(40) * 3 / 2) @(negedge clk);
    chk("R9 single up step on saturated drift", int'(div), 16);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_lock_two();
    t_drift_up();
    t_drift_down();
    t_high();
    t_low();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule